// File: doc/BRIEF.md
# Field and Region Vertical Sequence Selector

This block follows the line position inside each readout field of an image sensor and decides which stored vertical timing sequence governs the present line. Every field is split into regions by programmable start lines. A per-region mapping entry names a sequence index and can flag the region as a fast sweep region, with its own pulse count, or as the sensor-gate line. The block cycles through a programmable number of fields, so each field in a frame can carry its own region layout and mapping.

Software writes a shadow copy of the region layout, the mappings and the sweep counts through a simple write port. The shadow copy moves into the active copy on the next field strobe, so the timing never changes in the middle of a field. A separate polarity mask adapts the vertical pulse outputs and the substrate-clear output to an external driver that inverts them.

The write address is `{field, region, kind}`, with kind in the two low bits. For a field slot below NFIELD, kind 0 sets the region's start line from `wr_data[LINE_W-1:0]`. Kind 1 sets the mapping: sequence index in `wr_data[SEQ_W-1:0]`, sweep flag in bit SEQ_W and sensor-gate flag in bit SEQ_W+1. Kind 2 sets the sweep count from `wr_data[SWEEP_W-1:0]`. Field slot NFIELD is the global slot: kind 0 sets the enabled field count, and kind 1 sets the polarity mask, with bits [NVOUT-1:0] for the vertical outputs and bit NVOUT for substrate clear.

Top module: `vseq_region_sel`

## Requirements
- R1: After reset the line is 0, the region is 0 and the field is 0. `fsync` clears the line and the region to 0. Each `lsync` without `fsync` adds one to the line, which stops at its maximum value.
- R2: Region 0 starts at line 0, and the start line stored for region 0 is unused. When the line becomes equal to the active start line of the next region, the region advances by one and never passes NREGION-1.
- R3: Suppose the next region's start line is not greater than the current line, for example starts of 5, 3 and 8. The region then holds its value until the next `fsync`.
- R4: `seq_idx` shows the sequence index that the active mapping assigns to the current field and region. Two regions may carry the same index.
- R5: On each `fsync` the field advances by one. It wraps to 0 after field count-1 or after NFIELD-1, whichever comes first. A field count of 0 behaves like 1.
- R6: Writes to start lines, mappings and sweep counts take no effect on the outputs until the next `fsync`.
- R7: `sweep_en` and `sweep_cnt` show the sweep flag and the sweep count of the current active region.
- R8: `sg_line` shows the sensor-gate flag of the current active region.
- R9: `v_out` equals `v_in` XOR mask[NVOUT-1:0], and `subclr_out` equals `subclr_in` XOR mask[NVOUT], both with no register delay. The mask is 0 after reset.
- R10: When `fsync` and `lsync` arrive in the same cycle, `fsync` wins and the line becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsync | input | 1 | Line strobe, one cycle |
| fsync | input | 1 | Field strobe, one cycle |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | FAW+RW+2 | Write address {field, region, kind} |
| wr_data | input | DATA_W | Write data |
| v_in | input | NVOUT | Raw vertical pulses |
| subclr_in | input | 1 | Raw substrate-clear pulse |
| line_num | output | LINE_W | Current line within the field |
| region | output | RW | Current region |
| field | output | FAW | Current field |
| seq_idx | output | SEQ_W | Selected sequence index |
| sweep_en | output | 1 | Current region is a sweep region |
| sweep_cnt | output | SWEEP_W | Fast pulse count for the sweep region |
| sg_line | output | 1 | Current region is the sensor-gate line |
| v_out | output | NVOUT | Polarity-adjusted vertical pulses |
| subclr_out | output | 1 | Polarity-adjusted substrate clear |

## Verification
The assertions assume that the strobes are single-cycle pulses, sampled on the rising edge, and that no write addresses a field slot above NFIELD. The region and line properties also assume that lines within a field only move forward, which holds because the only way back to line 0 is `fsync`. The bench drives every strobe and write for exactly one cycle, from the falling edge. It sweeps each field with both ascending and out-of-order start lines, and it runs through field counts of 0, 2 and 3.

// File: rtl/vseq_region_sel.sv
module vseq_region_sel #(
  parameter int NFIELD  = 3,
  parameter int NREGION = 4,
  parameter int LINE_W  = 12,
  parameter int SEQ_W   = 4,
  parameter int SWEEP_W = 8,
  parameter int NVOUT   = 6,
  parameter int DATA_W  = 16,
  localparam int FAW = $clog2(NFIELD + 1),
  localparam int RW  = $clog2(NREGION),
  localparam int AW  = FAW + RW + 2,
  localparam int NE  = NFIELD * NREGION,
  localparam int CW  = SEQ_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lsync,
  input  logic               fsync,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NVOUT-1:0]   v_in,
  input  logic               subclr_in,
  output logic [LINE_W-1:0]  line_num,
  output logic [RW-1:0]      region,
  output logic [FAW-1:0]     field,
  output logic [SEQ_W-1:0]   seq_idx,
  output logic               sweep_en,
  output logic [SWEEP_W-1:0] sweep_cnt,
  output logic               sg_line,
  output logic [NVOUT-1:0]   v_out,
  output logic               subclr_out
);

  logic [LINE_W-1:0]  sh_bnd [NE], ac_bnd [NE];
  logic [CW-1:0]      sh_map [NE], ac_map [NE];
  logic [SWEEP_W-1:0] sh_cnt [NE], ac_cnt [NE];
  logic [FAW-1:0]     nf;
  logic [NVOUT:0]     pol;

  logic [FAW-1:0] wf;
  logic [RW-1:0]  wr;
  logic [1:0]     wk;
  assign wf = wr_addr[AW-1 -: FAW];
  assign wr = wr_addr[2 +: RW];
  assign wk = wr_addr[1:0];

  int unsigned cur, nxt;
  assign cur = int'(field) * NREGION + int'(region);
  assign nxt = cur + 1;

  logic [LINE_W-1:0] line_inc;
  logic              adv, wrap;
  assign line_inc = (&line_num) ? line_num : line_num + 1'b1;
  assign adv  = (int'(region) < NREGION - 1) && (ac_bnd[nxt] == line_inc);
  assign wrap = (int'(field) + 1 >= int'(nf)) || (int'(field) == NFIELD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        sh_bnd[i] <= '0; sh_map[i] <= '0; sh_cnt[i] <= '0;
      end
      nf  <= FAW'(NFIELD);
      pol <= '0;
    end else if (wr_en) begin
      if (int'(wf) == NFIELD) begin
        if (wk == 2'd0) nf  <= wr_data[FAW-1:0];
        if (wk == 2'd1) pol <= wr_data[NVOUT:0];
      end else if (int'(wf) < NFIELD) begin
        case (wk)
          2'd0: sh_bnd[int'(wf) * NREGION + int'(wr)] <= wr_data[LINE_W-1:0];
          2'd1: sh_map[int'(wf) * NREGION + int'(wr)] <= wr_data[CW-1:0];
          2'd2: sh_cnt[int'(wf) * NREGION + int'(wr)] <= wr_data[SWEEP_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        ac_bnd[i] <= '0; ac_map[i] <= '0; ac_cnt[i] <= '0;
      end
      line_num <= '0;
      region   <= '0;
      field    <= '0;
    end else if (fsync) begin
      ac_bnd   <= sh_bnd;
      ac_map   <= sh_map;
      ac_cnt   <= sh_cnt;
      line_num <= '0;
      region   <= '0;
      field    <= wrap ? '0 : field + 1'b1;
    end else if (lsync) begin
      line_num <= line_inc;
      if (adv) region <= region + 1'b1;
    end
  end

  assign seq_idx    = ac_map[cur][SEQ_W-1:0];
  assign sweep_en   = ac_map[cur][SEQ_W];
  assign sg_line    = ac_map[cur][SEQ_W+1];
  assign sweep_cnt  = ac_cnt[cur];
  assign v_out      = v_in ^ pol[NVOUT-1:0];
  assign subclr_out = subclr_in ^ pol[NVOUT];

  assert_fsync_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (line_num == '0) && (region == '0));
  assert_line_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lsync && !fsync && !(&line_num)) |=> line_num == $past(line_num) + 1'b1);
  assert_region_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lsync && !fsync) |=> region >= $past(region));
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsync && !fsync) |=> $stable(region) && $stable(field) && $stable(line_num));
  assert_field_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(field) < NFIELD);
  assert_map_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsync && !fsync) |=> $stable(seq_idx) && $stable(sweep_cnt) && $stable(sg_line));
  assert_fsync_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && lsync) |=> line_num == '0);

endmodule

// File: tb/vseq_region_sel_bench.sv
module vseq_region_sel_bench;
  localparam int NF = 3, NR = 4;

  logic clk = 0, rst_n = 0, lsync = 0, fsync = 0, wr_en = 0, subclr_in = 0;
  logic [5:0] wr_addr = '0, v_in = '0, v_out;
  logic [15:0] wr_data = '0;
  logic [11:0] line_num;
  logic [1:0] region, field;
  logic [3:0] seq_idx;
  logic [7:0] sweep_cnt;
  logic sweep_en, sg_line, subclr_out;

  always #2 clk = ~clk;

  vseq_region_sel u_vseq_region_sel (.*);

  int errors = 0, checks = 0;
  int b_bnd[NF][NR], b_seq[NF][NR], b_sw[NF][NR], b_sg[NF][NR], b_cnt[NF][NR];
  int a_bnd[NF][NR], a_seq[NF][NR], a_sw[NF][NR], a_sg[NF][NR], a_cnt[NF][NR];
  int e_line = 0, e_reg = 0, e_f = 0, e_nf = 3;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (field %0d line %0d)", req, act, exp, e_f, e_line);
    end
  endtask

  task automatic check_all();
    chk("R1 line", int'(line_num), e_line);
    chk("R2 region", int'(region), e_reg);
    chk("R5 field", int'(field), e_f);
    chk("R4 seq", int'(seq_idx), a_seq[e_f][e_reg]);
    chk("R7 sweep", int'(sweep_en), a_sw[e_f][e_reg]);
    chk("R7 count", int'(sweep_cnt), a_cnt[e_f][e_reg]);
    chk("R8 sg", int'(sg_line), a_sg[e_f][e_reg]);
  endtask

  task automatic wr(int f, int r, int k, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 6'((f << 4) | (r << 2) | k); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 0;
    if (f < NF) begin
      if (k == 0) b_bnd[f][r] = d;
      if (k == 1) begin b_seq[f][r] = d & 15; b_sw[f][r] = (d >> 4) & 1; b_sg[f][r] = (d >> 5) & 1; end
      if (k == 2) b_cnt[f][r] = d;
    end else if (k == 0) e_nf = d;
  endtask

  task automatic model_fsync();
    a_bnd = b_bnd; a_seq = b_seq; a_sw = b_sw; a_sg = b_sg; a_cnt = b_cnt;
    e_line = 0; e_reg = 0;
    e_f = (e_f + 1 >= e_nf || e_f == NF - 1) ? 0 : e_f + 1;
  endtask

  task automatic do_fsync(bit with_line);
    @(negedge clk); fsync = 1; lsync = with_line;
    @(negedge clk); fsync = 0; lsync = 0;
    model_fsync();
  endtask

  task automatic do_line();
    @(negedge clk); lsync = 1;
    @(negedge clk); lsync = 0;
    e_line++;
    if (e_reg < NR - 1 && a_bnd[e_f][e_reg + 1] == e_line) e_reg++;
  endtask

  task automatic sweep_field(int n);
    check_all();
    for (int l = 0; l < n; l++) begin do_line(); check_all(); end
  endtask

  initial begin
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) begin
        b_bnd[f][r] = 0; b_seq[f][r] = 0; b_sw[f][r] = 0; b_sg[f][r] = 0; b_cnt[f][r] = 0;
      end
    a_bnd = b_bnd; a_seq = b_seq; a_sw = b_sw; a_sg = b_sg; a_cnt = b_cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();
    chk("R9 reset mask", int'(v_out), 0);

    // R9: exhaustive polarity sweep
    wr(3, 0, 1, 7'b1_101001);
    for (int v = 0; v < 128; v++) begin
      v_in = 6'(v); subclr_in = v[6];
      #1;
      chk("R9 v_out", int'(v_out), (v & 63) ^ 6'b101001);
      chk("R9 subclr", int'(subclr_out), v[6] ^ 1);
    end

    // ascending layout, shared index in regions 1 and 3
    for (int f = 0; f < NF; f++)
      for (int r = 0; r < NR; r++) begin
        wr(f, r, 0, r * (f + 2));
        wr(f, r, 1, ((r == 3) ? f * 4 + 1 : f * 4 + r) | ((r == 0) << 4) | ((r == 2) << 5));
        wr(f, r, 2, 10 + f * 3 + r);
      end
    check_all();  // R6: nothing visible before fsync
    for (int k = 0; k < 2 * NF; k++) begin do_fsync(0); sweep_field(14); end

    // R6: mid-field write stays hidden until the field strobe
    wr(e_f, e_reg, 1, 15);
    wr(e_f, e_reg, 2, 200);
    check_all();
    chk("R6 hidden", int'(seq_idx), a_seq[e_f][e_reg]);

    // R3: out-of-order starts 5,3,8 in every field
    for (int f = 0; f < NF; f++) begin wr(f, 1, 0, 5); wr(f, 2, 0, 3); wr(f, 3, 0, 8); end
    for (int k = 0; k < NF; k++) begin
      do_fsync(0); sweep_field(12);
      chk("R3 held", int'(region), 1);
    end

    // R10: simultaneous strobes
    do_line(); do_line();
    do_fsync(1); check_all();
    chk("R10 line", int'(line_num), 0);

    // R5: field counts 2, 0, 3
    wr(3, 0, 0, 2);
    for (int k = 0; k < 5; k++) begin do_fsync(0); sweep_field(2); end
    wr(3, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin do_fsync(0); check_all(); end
    wr(3, 0, 0, 3);
    for (int k = 0; k < 4; k++) begin do_fsync(0); sweep_field(6); end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule